// File: doc/BRIEF.md
# Dual-Mode Burst Memory Port Controller

This block holds the control logic on the memory side of a 32-bit memory port. The port runs in one of two access modes. In the asynchronous mode, reads and writes follow the level of the strobes. In the clocked burst mode, the block captures a start address on a clock edge and then steps through a short burst, one word on each advance. The block keeps the current mode in a register. It produces a data-drive enable that stands in for the pad output enable and a write-sample strobe. A small internal word array stands in for the storage, so the port can be exercised from end to end.

A configuration input selects the mode. An active-low reset/power-down pin stops all activity and always brings the block back in asynchronous array-read mode. In the clocked mode, the address-load strobe wins over the advance strobe at the same edge. The output-disable pin wins over output enable in both modes.

Top module: `bmem_port_ctrl`

## Requirements
- R1: In clocked mode (`sync_mode`=1), a rising edge with `ce_n`=0 and `ld_n`=0 loads `addr_in` into `burst_addr`. The load takes priority over `adv_n` at the same edge. In asynchronous mode, `burst_addr` does not move.
- R2: At that load edge, `addr_is_write` takes the value of the inverted `wr_sel` (0 selects a write address, 1 selects a read address). It holds that value until the next load.
- R3: In clocked mode, a rising edge with `ce_n`=0, `ld_n`=1 and `adv_n`=0 increments the low 2 bits of `burst_addr`, wrapping 3 to 0 inside the 4-word aligned group, and leaves the upper bits unchanged. With `adv_n`=1, `burst_addr` holds its value.
- R4: In clocked mode, a rising edge that samples `ce_n`=0, `oe_n`=0 and `od_n`=1 sets `drive_en` for the following cycle. While `drive_en` is 1, `dout` shows the array word at `burst_addr`; while `drive_en` is 0, `dout` is 0.
- R5: In clocked mode, a rising edge that samples `od_n`=0 clears `drive_en` for the following cycle, whatever `oe_n` is.
- R6: In asynchronous mode, `drive_en` = !`ce_n` && !`oe_n` && `od_n`, with no clock delay. `dout` then shows the word at `addr_in`, and `od_n`=0 blocks the drive at once.
- R7: `wr_strobe` = !`ce_n` && !`we_n` in both modes. At a rising edge with `wr_strobe`=1, `din` is written to the word at `addr_in` (asynchronous mode) or at `burst_addr` (clocked mode).
- R8: In asynchronous mode, `ld_n` has no effect on the address. If `ld_n` is 1 at one edge and 0 now, with `ce_n`=0 and `we_n`=1, `rd_restart` is 1 for that cycle only.
- R9: While `rst_n`=0, `drive_en`, `wr_strobe` and `rd_restart` are 0 and `dout` is 0. After release, `sync_mode`=0, `burst_addr`=0 and `addr_is_write`=0.
- R10: With `ce_n`=1, `drive_en` and `wr_strobe` are 0, and no load, advance or array write takes place.
- R11: A rising edge with `cfg_wr`=1 loads `cfg_sync` into `sync_mode` (1 = clocked burst, 0 = asynchronous).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset/power-down |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| od_n | input | 1 | Active-low output disable, overrides oe_n |
| we_n | input | 1 | Active-low write enable |
| ld_n | input | 1 | Active-low burst address load strobe |
| wr_sel | input | 1 | Address type at load: 0 write, 1 read |
| adv_n | input | 1 | Active-low burst advance strobe |
| cfg_wr | input | 1 | Mode register write enable |
| cfg_sync | input | 1 | Mode value: 1 clocked, 0 asynchronous |
| addr_in | input | 6 | Word address |
| din | input | 32 | Write data |
| dout | output | 32 | Read data, 0 when not driving |
| drive_en | output | 1 | Data output drive enable |
| wr_strobe | output | 1 | Write-sample strobe |
| rd_restart | output | 1 | Asynchronous read restart pulse |
| sync_mode | output | 1 | Current mode register |
| burst_addr | output | 6 | Current burst word address |
| addr_is_write | output | 1 | Type of the last loaded address |

## Verification
The bench builds the block with its default parameters: 64 words and a 4-word burst group. With these values the whole array can be filled and read back in a short run, and a burst started near the top of a group crosses the wrap point within a few beats. Loads at offsets 1 and 2 within a group, and a write burst that wraps before it is read back, check the wrap arithmetic against write addresses and read addresses alike.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  typedef enum logic {
    MODE_ASYNC   = 1'b0,
    MODE_CLOCKED = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/bmem_burst_ctr.sv
module bmem_burst_ctr #(
  parameter int AW = 6,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          adv_en,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_sel,
  output logic [AW-1:0] cur_addr,
  output logic          is_write
);
  logic [AW-1:0] addr_q, addr_d, addr_step;
  logic          isw_q, isw_d;

  // wrap variant chosen by the burst group width
  generate
    if (OW == 0) begin : g_nowrap
      assign addr_step = addr_q;
    end else if (OW >= AW) begin : g_fullwrap
      localparam logic [AW-1:0] ONE_A = 1;
      assign addr_step = addr_q + ONE_A;
    end else begin : g_groupwrap
      localparam logic [OW-1:0] ONE_O = 1;
      logic [OW-1:0] low_inc;
      assign low_inc   = addr_q[OW-1:0] + ONE_O;
      assign addr_step = {addr_q[AW-1:OW], low_inc};
    end
  endgenerate

  always_comb begin
    addr_d = addr_q;
    isw_d  = isw_q;
    if (load_en) begin
      addr_d = addr_in;
      isw_d  = ~wr_sel;
    end else if (adv_en) begin
      addr_d = addr_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      isw_q  <= 1'b0;
    end else if (load_en || adv_en) begin
      addr_q <= addr_d;
      isw_q  <= isw_d;
    end
  end

  assign cur_addr = addr_q;
  assign is_write = isw_q;
endmodule

// File: rtl/bmem_out_ctl.sv
module bmem_out_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sync,
  input  logic ce_n,
  input  logic oe_n,
  input  logic od_n,
  input  logic we_n,
  input  logic ld_n,
  output logic drive_en,
  output logic wr_strobe,
  output logic rd_restart
);
  logic drv_q, drv_d;
  logic ld_q, ld_d;

  always_comb begin
    drv_d = ~ce_n & ~oe_n & od_n;
    ld_d  = ld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      ld_q  <= 1'b1;
    end else begin
      drv_q <= drv_d;
      ld_q  <= ld_d;
    end
  end

  always_comb begin
    drive_en   = rst_n & ~ce_n & (mode_sync ? drv_q : (~oe_n & od_n));
    wr_strobe  = rst_n & ~ce_n & ~we_n;
    rd_restart = rst_n & ~mode_sync & ~ce_n & we_n & ld_q & ~ld_n;
  end
endmodule

// File: rtl/bmem_array.sv
module bmem_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          wen,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bmem_port_ctrl.sv
module bmem_port_ctrl
  import bmem_pkg::*;
#(
  parameter int DW        = 32,
  parameter int DEPTH     = 64,
  parameter int BURST_LEN = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int OW       = $clog2(BURST_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          od_n,
  input  logic          we_n,
  input  logic          ld_n,
  input  logic          wr_sel,
  input  logic          adv_n,
  input  logic          cfg_wr,
  input  logic          cfg_sync,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          drive_en,
  output logic          wr_strobe,
  output logic          rd_restart,
  output logic          sync_mode,
  output logic [AW-1:0] burst_addr,
  output logic          addr_is_write
);
  acc_mode_e     mode_q, mode_d;
  logic          is_sync, load_en, adv_en;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] rdata;

  always_comb begin
    mode_d = cfg_wr ? acc_mode_e'(cfg_sync) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= MODE_ASYNC;
    else if (cfg_wr) mode_q <= mode_d;
  end

  always_comb begin
    is_sync  = (mode_q == MODE_CLOCKED);
    load_en  = is_sync & ~ce_n & ~ld_n;
    adv_en   = is_sync & ~ce_n & ~adv_n;
    acc_addr = is_sync ? burst_addr : addr_in;
  end

  bmem_burst_ctr #(.AW(AW), .OW(OW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .adv_en   (adv_en),
    .addr_in  (addr_in),
    .wr_sel   (wr_sel),
    .cur_addr (burst_addr),
    .is_write (addr_is_write)
  );

  bmem_out_ctl u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sync  (is_sync),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .od_n       (od_n),
    .we_n       (we_n),
    .ld_n       (ld_n),
    .drive_en   (drive_en),
    .wr_strobe  (wr_strobe),
    .rd_restart (rd_restart)
  );

  bmem_array #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .wen   (wr_strobe),
    .addr  (acc_addr),
    .wdata (din),
    .rdata (rdata)
  );

  assign dout      = drive_en ? rdata : '0;
  assign sync_mode = is_sync;
endmodule

// File: rtl/bmem_port_ctrl_chk.sv
module bmem_port_ctrl_chk #(
  parameter int AW = 6,
  parameter int OW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          od_n,
  input logic          ld_n,
  input logic          adv_n,
  input logic          wr_sel,
  input logic          cfg_wr,
  input logic          cfg_sync,
  input logic [AW-1:0] addr_in,
  input logic          drive_en,
  input logic          wr_strobe,
  input logic          rd_restart,
  input logic          sync_mode,
  input logic [AW-1:0] burst_addr,
  input logic          addr_is_write
);
  always_comb begin
    if (!rst_n) begin
      assert_quiet_in_reset_R9 : assert (!drive_en && !wr_strobe && !rd_restart);
    end
  end

  assert_load_addr_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !ce_n && !ld_n) |=> (burst_addr == $past(addr_in)));

  assert_load_type_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !ce_n && !ld_n) |=> (addr_is_write == !$past(wr_sel)));

  assert_adv_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !ce_n && ld_n && !adv_n) |=>
      (burst_addr[OW-1:0] == OW'($past(burst_addr[OW-1:0]) + 1'b1)) &&
      (burst_addr[AW-1:OW] == $past(burst_addr[AW-1:OW])));

  assert_adv_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && ld_n && adv_n) |=> $stable(burst_addr));

  assert_sync_drive_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !cfg_wr && !ce_n && !oe_n && od_n) |=> (drive_en || ce_n));

  assert_od_wins_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !cfg_wr && !od_n) |=> !drive_en);

  assert_deselect_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!drive_en && !wr_strobe && !rd_restart));

  assert_mode_load_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (sync_mode == $past(cfg_sync)));
endmodule

bind bmem_port_ctrl bmem_port_ctrl_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ce_n          (ce_n),
  .oe_n          (oe_n),
  .od_n          (od_n),
  .ld_n          (ld_n),
  .adv_n         (adv_n),
  .wr_sel        (wr_sel),
  .cfg_wr        (cfg_wr),
  .cfg_sync      (cfg_sync),
  .addr_in       (addr_in),
  .drive_en      (drive_en),
  .wr_strobe     (wr_strobe),
  .rd_restart    (rd_restart),
  .sync_mode     (sync_mode),
  .burst_addr    (burst_addr),
  .addr_is_write (addr_is_write)
);

// File: tb/bmem_port_ctrl_tb.sv
module bmem_port_ctrl_tb;
  localparam int DEPTH = 64;
  localparam int BL    = 4;

  logic        clk = 1'b0;
  logic        rst_n, ce_n, oe_n, od_n, we_n, ld_n, wr_sel, adv_n, cfg_wr, cfg_sync;
  logic [5:0]  addr_in;
  logic [31:0] din, dout;
  logic        drive_en, wr_strobe, rd_restart, sync_mode, addr_is_write;
  logic [5:0]  burst_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // reference model state
  int mem_m [DEPTH];
  int m_mode, m_baddr, m_isw, m_drv, m_ldq;

  always #2 clk = ~clk;

  bmem_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .od_n(od_n),
    .we_n(we_n), .ld_n(ld_n), .wr_sel(wr_sel), .adv_n(adv_n),
    .cfg_wr(cfg_wr), .cfg_sync(cfg_sync), .addr_in(addr_in), .din(din),
    .dout(dout), .drive_en(drive_en), .wr_strobe(wr_strobe),
    .rd_restart(rd_restart), .sync_mode(sync_mode),
    .burst_addr(burst_addr), .addr_is_write(addr_is_write)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_baddr = 0; m_isw = 0; m_drv = 0; m_ldq = 1;
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; od_n = 1; we_n = 1; ld_n = 1; wr_sel = 1;
    adv_n = 1; cfg_wr = 0; cfg_sync = 0; addr_in = '0; din = '0;
  endtask

  // compare all outputs against the model, then advance one clock
  task automatic cyc(string tag);
    int  acc, wa;
    bit  edrv, ewr, erst;
    #1;
    if (!rst_n) model_reset();
    acc  = (m_mode != 0) ? m_baddr : int'(addr_in);
    edrv = rst_n && !ce_n && ((m_mode != 0) ? (m_drv != 0) : (!oe_n && od_n));
    ewr  = rst_n && !ce_n && !we_n;
    erst = rst_n && (m_mode == 0) && !ce_n && we_n && (m_ldq != 0) && !ld_n;
    chk(tag, "drive_en", 32'(drive_en), 32'(edrv));
    chk(tag, "dout", dout, edrv ? 32'(mem_m[acc]) : 32'h0);
    chk(tag, "wr_strobe", 32'(wr_strobe), 32'(ewr));
    chk(tag, "rd_restart", 32'(rd_restart), 32'(erst));
    chk(tag, "sync_mode", 32'(sync_mode), 32'(m_mode));
    chk(tag, "burst_addr", 32'(burst_addr), 32'(m_baddr));
    chk(tag, "addr_is_write", 32'(addr_is_write), 32'(m_isw));
    @(posedge clk);
    if (!rst_n) begin
      model_reset();
    end else begin
      wa = acc;
      if (ewr) mem_m[wa] = int'(din);
      if ((m_mode != 0) && !ce_n) begin
        if (!ld_n) begin
          m_baddr = int'(addr_in);
          m_isw   = wr_sel ? 0 : 1;
        end else if (!adv_n) begin
          m_baddr = (m_baddr & ~(BL-1)) | ((m_baddr + 1) & (BL-1));
        end
      end
      m_drv = (!ce_n && !oe_n && od_n) ? 1 : 0;
      m_ldq = ld_n ? 1 : 0;
      if (cfg_wr) m_mode = cfg_sync ? 1 : 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 0;
    model_reset();
    idle();
    rst_n = 0;
    @(negedge clk);

    // R9: activity blocked during reset even with all strobes asserted
    ce_n = 0; oe_n = 0; we_n = 0; ld_n = 0; adv_n = 0;
    cyc("R9"); cyc("R9");
    idle(); rst_n = 1;
    cyc("R9");

    // R7: asynchronous writes fill the array
    for (int i = 0; i < DEPTH; i++) begin
      ce_n = 0; we_n = 0; addr_in = 6'(i); din = 32'hA500_0000 + 32'(i * 7);
      cyc("R7");
    end
    idle();

    // R6: asynchronous reads, output disable override
    for (int i = 0; i < 8; i++) begin
      ce_n = 0; oe_n = 0; addr_in = 6'(i * 9);
      cyc("R6");
    end
    od_n = 0; cyc("R6");
    od_n = 1; cyc("R6");

    // R10: deselected async
    ce_n = 1; oe_n = 0; we_n = 0; addr_in = 6'd3; din = 32'hDEAD;
    cyc("R10"); cyc("R10");
    idle();

    // R8: load strobe in async mode
    ce_n = 0; oe_n = 0; addr_in = 6'd20;
    cyc("R8");
    ld_n = 0; cyc("R8");
    cyc("R8");
    ld_n = 1; cyc("R8");
    we_n = 0; din = 32'h1234_5678; ld_n = 0; cyc("R8");
    idle();

    // R11: switch to clocked mode
    cfg_wr = 1; cfg_sync = 1; cyc("R11");
    idle(); cyc("R11");

    // R1 R2 R3 R4: read burst from 13, wrap within group 12..15
    ce_n = 0; ld_n = 0; wr_sel = 1; addr_in = 6'd13; oe_n = 0;
    cyc("R1");
    ld_n = 1; adv_n = 0;
    for (int i = 0; i < 6; i++) cyc("R3");
    adv_n = 1; cyc("R3"); cyc("R3");
    adv_n = 0; cyc("R4");

    // R5: output disable at sampled edge
    od_n = 0; cyc("R5"); cyc("R5");
    od_n = 1; cyc("R5"); cyc("R4");
    oe_n = 1; cyc("R4"); cyc("R4");

    // R2 R7: write burst at 6, wraps 6,7,4,5
    adv_n = 1; ld_n = 0; wr_sel = 0; addr_in = 6'd6;
    cyc("R2");
    ld_n = 1; wr_sel = 1; we_n = 0; adv_n = 0;
    for (int i = 0; i < 4; i++) begin
      din = 32'hC0DE_0000 + 32'(i);
      cyc("R7");
    end
    we_n = 1; adv_n = 1;

    // R4: read back from 4
    ld_n = 0; wr_sel = 1; addr_in = 6'd4; oe_n = 0;
    cyc("R2");
    ld_n = 1; adv_n = 0;
    for (int i = 0; i < 5; i++) cyc("R4");

    // R10: deselected clocked mode ignores load, advance and write
    ce_n = 1; ld_n = 0; adv_n = 0; we_n = 0; addr_in = 6'd40; din = 32'hBAD;
    cyc("R10"); cyc("R10");
    ce_n = 0; ld_n = 1; adv_n = 1; we_n = 1; cyc("R10");

    // R1: load wins over advance
    ld_n = 0; adv_n = 0; addr_in = 6'd50; cyc("R1");
    ld_n = 1; cyc("R1"); cyc("R1");
    idle();

    // R9: mid-run reset returns to asynchronous mode
    rst_n = 0; ce_n = 0; oe_n = 0; cyc("R9"); cyc("R9");
    rst_n = 1; idle(); cyc("R9");
    ce_n = 0; oe_n = 0; addr_in = 6'd5; cyc("R9");
    idle(); cyc("R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule